// File: doc/BRIEF.md
# Prioritized Masked Round-Robin Arbiter

This block picks one winner among four requesters on a crossbar channel. Each requester carries a static priority level from 0 to 3. In every cycle only the highest level that has an active request competes. Within that level the winner is chosen by a rotating mask, so that requesters of equal rank take turns.

Each priority level keeps its own rotation mask. A higher level that takes over the channel therefore does not disturb where a lower level's rotation will resume. The grant is purely combinational. The mask of the level that was served moves on only when the `advance_i` input reports that the granted transfer has finished.

Top module: `prio_rr_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set, and it is all zeros whenever `req_i` is all zeros.
- R2: A grant bit is set only for a requester whose request bit is set. Requester k is bit k, so requester 0 is the LSB and requester 3 is the MSB.
- R3: Requester k takes its level from `prio_i[2k+1:2k]`, and a larger value means higher priority. Only requesters at the highest level that has any active request can be granted.
- R4: Within the competing level, the grant goes to the lowest set bit of (level requests AND that level's mask).
- R5: If (level requests AND mask) is zero, the grant goes to the lowest active request of that level.
- R6: When `advance_i` is high and a grant is given, the served level's mask becomes the bits strictly above the granted position. If the grant is bit 3, the mask becomes all ones instead.
- R7: After reset every level's mask is all ones.
- R8: No mask changes when `advance_i` is low. The masks of levels that were not served are never changed.
- R9: With all levels equal, requests 1101 held and `advance_i` high from reset, the grants run 0001, 0100, 1000, 0001.
- R10: With equal levels, a requester that holds its request is granted before any other requester is granted twice, that is, within 3 foreign grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 4 | Request vector, bit k for requester k |
| prio_i | input | 8 | Packed 2-bit priority level per requester |
| advance_i | input | 1 | The granted transfer completes this cycle; update the served mask |
| grant_o | output | 4 | One-hot grant, combinational |

## Verification
Two things can happen in the same cycle: a higher level preempts the channel while `advance_i` is high, and a lower level holds a half-rotated mask. The bench provokes this by advancing a lower level part way through its rotation, then raising a higher-priority request and advancing it. It then drops that request and checks that the lower level resumes exactly where it left off, not from a reset mask. A second case joins the fall-back selection with an advance. Here the grant must come from the lowest request, and the next grant must follow from the mask rebuilt from that fall-back grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_NREQ_DEF = 4;
  localparam int unsigned ARB_NLVL_DEF = 4;
endpackage

// File: rtl/arb_level_sel.sv
module arb_level_sel #(
  parameter int unsigned NREQ = 4,
  parameter int unsigned NLVL = 4,
  parameter int unsigned LVLW = 2
) (
  input  logic [NREQ-1:0]      req,
  input  logic [NREQ*LVLW-1:0] prio_flat,
  output logic [LVLW-1:0]      top_lvl,
  output logic [NREQ-1:0]      lvl_req
);
  logic seen;

  always_comb begin
    top_lvl = '0;
    seen    = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (req[i] && (!seen || prio_flat[i*LVLW +: LVLW] > top_lvl)) begin
        top_lvl = prio_flat[i*LVLW +: LVLW];
      end
      if (req[i]) seen = 1'b1;
    end
    for (int i = 0; i < NREQ; i++) begin
      lvl_req[i] = req[i] && (prio_flat[i*LVLW +: LVLW] == top_lvl);
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned NREQ = 4
) (
  input  logic [NREQ-1:0] req,
  input  logic [NREQ-1:0] mask,
  output logic [NREQ-1:0] grant,
  output logic [NREQ-1:0] next_mask
);
  logic [NREQ-1:0] masked;
  logic [NREQ-1:0] cand;

  always_comb begin
    masked = req & mask;
    cand   = (|masked) ? masked : req;
    grant  = cand & (~cand + {{(NREQ-1){1'b0}}, 1'b1});
    if (grant[NREQ-1]) next_mask = '1;
    else               next_mask = ~(grant | (grant - {{(NREQ-1){1'b0}}, 1'b1}));
  end
endmodule

// File: rtl/arb_mask_bank.sv
module arb_mask_bank #(
  parameter int unsigned NREQ = 4,
  parameter int unsigned NLVL = 4,
  parameter int unsigned LVLW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [LVLW-1:0] lvl,
  input  logic [NREQ-1:0] new_mask,
  output logic [NREQ-1:0] cur_mask
);
  logic [NREQ-1:0] mask_q [NLVL];
  logic [NREQ-1:0] mask_d [NLVL];
  logic [NLVL-1:0] lvl_en;

  always_comb begin
    for (int l = 0; l < NLVL; l++) begin
      lvl_en[l] = upd && (lvl == LVLW'(l));
      mask_d[l] = new_mask;
    end
  end

  generate
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q[l] <= '1;
        else if (lvl_en[l]) mask_q[l] <= mask_d[l];
      end

      AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_en[l] |=> $stable(mask_q[l])); // R8

      AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[l] != '0); // R6
    end
  endgenerate

  assign cur_mask = mask_q[lvl];
endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter #(
  parameter  int unsigned NREQ = arb_pkg::ARB_NREQ_DEF,
  parameter  int unsigned NLVL = arb_pkg::ARB_NLVL_DEF,
  localparam int unsigned LVLW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREQ-1:0]      req_i,
  input  logic [NREQ*LVLW-1:0] prio_i,
  input  logic                 advance_i,
  output logic [NREQ-1:0]      grant_o
);
  logic [LVLW-1:0] top_lvl;
  logic [NREQ-1:0] lvl_req;
  logic [NREQ-1:0] cur_mask;
  logic [NREQ-1:0] nxt_mask;
  logic            mask_upd;

  arb_level_sel #(.NREQ(NREQ), .NLVL(NLVL), .LVLW(LVLW)) u_sel (
    .req(req_i), .prio_flat(prio_i), .top_lvl(top_lvl), .lvl_req(lvl_req)
  );

  arb_rr_pick #(.NREQ(NREQ)) u_pick (
    .req(lvl_req), .mask(cur_mask), .grant(grant_o), .next_mask(nxt_mask)
  );

  assign mask_upd = advance_i && (|grant_o);

  arb_mask_bank #(.NREQ(NREQ), .NLVL(NLVL), .LVLW(LVLW)) u_bank (
    .clk(clk), .rst_n(rst_n), .upd(mask_upd), .lvl(top_lvl),
    .new_mask(nxt_mask), .cur_mask(cur_mask)
  );

  // checker logic: level of the winner against the highest requesting level
  logic [LVLW-1:0] chk_max;
  logic [LVLW-1:0] chk_gnt;
  always_comb begin
    chk_max = '0;
    chk_gnt = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_i[i] && prio_i[i*LVLW +: LVLW] > chk_max) chk_max = prio_i[i*LVLW +: LVLW];
      if (grant_o[i]) chk_gnt = prio_i[i*LVLW +: LVLW];
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R1
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> (grant_o == '0)); // R1
  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~req_i) == '0); // R2
  AST_BUSY_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |-> (grant_o != '0)); // R5
  AST_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> (chk_gnt == chk_max)); // R3
endmodule

// File: tb/sim_prio_rr_arbiter.sv
`timescale 1ns/1ps
module sim_prio_rr_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req;
  logic [7:0] prio;
  logic       adv;
  logic [3:0] grant;
  int         tests = 0;
  int         fails = 0;
  bit         done  = 1'b0;

  always #2.5 clk = ~clk;

  prio_rr_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio),
    .advance_i(adv), .grant_o(grant)
  );

  // {rst, req, prio, adv, expected grant, tag}
  localparam int NV = 28;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 4'b1101, 8'h00, 1'b1, 4'b0001, 4'd9},
    {1'b0, 4'b1101, 8'h00, 1'b1, 4'b0100, 4'd9},
    {1'b0, 4'b1101, 8'h00, 1'b1, 4'b1000, 4'd9},
    {1'b0, 4'b1101, 8'h00, 1'b1, 4'b0001, 4'd9},
    {1'b0, 4'b1111, 8'h00, 1'b1, 4'b0010, 4'd4},
    {1'b0, 4'b1111, 8'h00, 1'b1, 4'b0100, 4'd4},
    {1'b0, 4'b1111, 8'h00, 1'b1, 4'b1000, 4'd6},
    {1'b0, 4'b1111, 8'h00, 1'b1, 4'b0001, 4'd6},
    {1'b0, 4'b0011, 8'h00, 1'b1, 4'b0010, 4'd4},
    {1'b0, 4'b0011, 8'h00, 1'b1, 4'b0001, 4'd5},
    {1'b0, 4'b0111, 8'h00, 1'b1, 4'b0010, 4'd4},
    {1'b0, 4'b0111, 8'h00, 1'b1, 4'b0100, 4'd4},
    {1'b0, 4'b1111, 8'h00, 1'b0, 4'b1000, 4'd8},
    {1'b0, 4'b1111, 8'h00, 1'b0, 4'b1000, 4'd8},
    {1'b0, 4'b1111, 8'h00, 1'b1, 4'b1000, 4'd6},
    {1'b0, 4'b1111, 8'h00, 1'b1, 4'b0001, 4'd6},
    {1'b1, 4'b1111, 8'h20, 1'b1, 4'b0100, 4'd3},
    {1'b0, 4'b1011, 8'h20, 1'b1, 4'b0001, 4'd3},
    {1'b0, 4'b1011, 8'h20, 1'b1, 4'b0010, 4'd4},
    {1'b0, 4'b1111, 8'h20, 1'b1, 4'b0100, 4'd5},
    {1'b0, 4'b1011, 8'h20, 1'b1, 4'b1000, 4'd8},
    {1'b0, 4'b0000, 8'h20, 1'b1, 4'b0000, 4'd1},
    {1'b0, 4'b1011, 8'h20, 1'b1, 4'b0001, 4'd6},
    {1'b1, 4'b1111, 8'hCD, 1'b1, 4'b0010, 4'd3},
    {1'b0, 4'b1111, 8'hCD, 1'b1, 4'b1000, 4'd4},
    {1'b0, 4'b0101, 8'hCD, 1'b1, 4'b0001, 4'd3},
    {1'b0, 4'b0100, 8'hCD, 1'b1, 4'b0100, 4'd3},
    {1'b0, 4'b1111, 8'hCD, 1'b1, 4'b0010, 4'd8}
  };

  function automatic string rtag(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; prio = '0; adv = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive at the falling edge, sample 1 ns later; the rising edge commits the mask
  task automatic step(input logic [3:0] r, input logic [7:0] p, input logic a);
    @(negedge clk);
    req = r; prio = p; adv = a;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; prio = '0; adv = 1'b0;
    do_reset();

    // reset state: no requests, no grant
    step(4'b0000, 8'h00, 1'b0);
    check("R1 reset idle", grant, 4'b0000);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][21]) do_reset();
      step(VEC[v][20:17], VEC[v][16:9], VEC[v][8]);
      check(rtag(int'(VEC[v][3:0])), grant, VEC[v][7:4]);
    end

    // R7: leave mask at 1100, reset, then 1001 must give 0001 (a stale mask would give 1000)
    do_reset();
    step(4'b1111, 8'h00, 1'b1);
    step(4'b1111, 8'h00, 1'b1);
    check("R7 pre", grant, 4'b0010);
    do_reset();
    step(4'b1001, 8'h00, 1'b0);
    check("R7", grant, 4'b0001);

    // R8: an advance with no request leaves the mask untouched
    step(4'b1111, 8'h00, 1'b1);
    check("R8 setup", grant, 4'b0001);
    step(4'b0000, 8'h00, 1'b1);
    check("R8 idle", grant, 4'b0000);
    step(4'b1111, 8'h00, 1'b1);
    check("R8 resume", grant, 4'b0010);

    // R1 R2 R3: random requests and levels
    for (int n = 0; n < 2000; n++) begin
      logic [3:0] r;
      logic [7:0] p;
      logic [3:0] allowed;
      logic [1:0] mx;
      r = 4'($urandom);
      p = 8'($urandom);
      step(r, p, 1'($urandom));
      mx = 2'd0;
      for (int k = 0; k < 4; k++) if (r[k] && p[2*k +: 2] > mx) mx = p[2*k +: 2];
      allowed = '0;
      for (int k = 0; k < 4; k++) allowed[k] = r[k] && (p[2*k +: 2] == mx);
      tests++;
      if (!$onehot0(grant) || ((r == 0) != (grant == 0))) begin
        fails++;
        $display("FAIL R1: grant=%b req=%b expected one-hot, zero only when idle", grant, r);
      end
      tests++;
      if ((grant & ~allowed) != 0) begin
        fails++;
        $display("FAIL R2/R3: grant=%b expected within %b (req=%b prio=%h)", grant, allowed, r, p);
      end
    end

    // R10: fairness with equal levels and sticky requests
    do_reset();
    begin
      logic [3:0] pend;
      int         waits [4];
      pend = '0;
      for (int k = 0; k < 4; k++) waits[k] = 0;
      for (int n = 0; n < 3000; n++) begin
        pend = pend | 4'($urandom);
        step(pend, 8'h00, 1'b1);
        for (int k = 0; k < 4; k++) begin
          if (grant[k]) begin
            tests++;
            if (waits[k] > 3) begin
              fails++;
              $display("FAIL R10: requester %0d waited %0d grants, expected <= 3", k, waits[k]);
            end
            waits[k] = 0;
          end else if (pend[k]) begin
            waits[k]++;
          end
        end
        pend = pend & ~grant;
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule